// File: doc/BRIEF.md
# Coded Power-of-Two Clock Divider

This block derives a core clock from a faster source clock. A 4-bit selection code either switches the output off or picks a division ratio that is a power of two, from 64 down to 1. Small nonzero codes give the slowest clocks and larger codes the faster ones. The block also raises a clock-enable flag whenever the code is nonzero. Codes with the top bit set are reserved and keep the output low.

Every divided output has a 50 % duty cycle. The code is taken into the divider only at the end of a low phase of the output. Because of that, a change of setting while the clock runs never cuts a high or low phase short. Division by one does not use the counter. It gates the source clock through an enable that changes only while the source is low.

Top module: `core_clk_div`

## Requirements
- R1: With code 0000 the output clock `clk_out` stays low.
- R2: Codes 0001 to 0110 divide the source by 64, 32, 16, 8, 4 and 2. Each high and each low phase of `clk_out` lasts H = 2^(6-code) source cycles: 32, 16, 8, 4, 2 and 1.
- R3: Code 0111 makes `clk_out` follow `clk_in`: high while the source is high, low while it is low.
- R4: Every code with bit 3 set (1000 to 1111) keeps `clk_out` low.
- R5: `clk_en` is 1 exactly when `div_code` is not 0000. This includes the reserved codes. It follows the code input without delay.
- R6: While `rst` is high, `clk_out` is low and the divider state is cleared. After reset with code 0000 the clock stays off.
- R7: A new code takes effect only at the end of a low phase. A high phase in progress, and the low phase after it, both complete at the old length. Every phase after that has the new length.
- R8: When the clock is switched on from off, the first high phase is preceded by a full low phase of H source cycles of the new setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| div_code | input | 4 | Division selection code |
| clk_out | output | 1 | Divided (or gated) core clock |
| clk_en | output | 1 | High when the code is nonzero |

## Verification
A table of codes is run through in an order that alternates slow and fast settings. After each code has settled, the high and low run lengths of the output are measured against H. This shows that each code maps to its own ratio and not to a neighbouring one. The off code and two reserved codes are each checked to hold the output low, while the enable flag still tells them apart. Directed sequences do three things:
- They switch from slow to fast and from fast to slow in the middle of a high phase. The four run lengths that follow show whether the change was deferred to the end of the low phase.
- They start the clock from off and check the length of the leading low phase.
- They sample the pass-through code on both source phases.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int CODE_W  = 4;
  localparam int MAX_EXP = 6;
  localparam int CNT_W   = MAX_EXP - 1;
  localparam logic [CODE_W-1:0] CODE_OFF  = '0;
  localparam logic [CODE_W-1:0] CODE_PASS = CODE_W'(MAX_EXP + 1);

  function automatic logic is_div(input logic [CODE_W-1:0] c);
    return (c != CODE_OFF) && (c < CODE_PASS);
  endfunction

  function automatic logic is_pass(input logic [CODE_W-1:0] c);
    return c == CODE_PASS;
  endfunction

  // Half-period length in source cycles; zero when the code does not divide.
  function automatic logic [CNT_W:0] half_len(input logic [CODE_W-1:0] c);
    logic [CNT_W:0] one;
    one = {{CNT_W{1'b0}}, 1'b1};
    if (!is_div(c)) return '0;
    return one << (MAX_EXP - int'(c));
  endfunction

  // Counter value on which a half-period ends.
  function automatic logic [CNT_W-1:0] last_tick(input logic [CODE_W-1:0] c);
    logic [CNT_W:0] h;
    h = half_len(c) - {{CNT_W{1'b0}}, 1'b1};
    return h[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/cdiv_code_reg.sv
module cdiv_code_reg
  import cdiv_pkg::*;
(
  input  logic              clk_in,
  input  logic              rst,
  input  logic              load_pt,
  input  logic [CODE_W-1:0] new_code,
  output logic [CODE_W-1:0] act_code
);
  always_ff @(posedge clk_in) begin
    if (rst)          act_code <= CODE_OFF;
    else if (load_pt) act_code <= new_code;
  end
endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter
  import cdiv_pkg::*;
(
  input  logic              clk_in,
  input  logic              rst,
  input  logic [CODE_W-1:0] act_code,
  input  logic [CODE_W-1:0] new_code,
  output logic              div_q,
  output logic              load_pt
);
  logic [CNT_W-1:0] cnt;
  logic             at_end;

  assign at_end  = (cnt == last_tick(act_code));
  // Safe point: counter not in use, or the low phase is ending.
  assign load_pt = !is_div(act_code) || (!div_q && at_end);

  always_ff @(posedge clk_in) begin
    if (rst) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (load_pt) begin
      cnt   <= '0;
      div_q <= is_div(act_code) && is_div(new_code);
    end else if (at_end) begin
      cnt   <= '0;
      div_q <= ~div_q;
    end else begin
      cnt   <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  // R1
  off_low_chk: assert property (@(posedge clk_in) disable iff (rst)
    !is_div(act_code) |=> !div_q);

  // R2
  cnt_range_chk: assert property (@(posedge clk_in) disable iff (rst)
    is_div(act_code) |-> ({1'b0, cnt} < half_len(act_code)));
endmodule

// File: rtl/cdiv_pass_gate.sv
module cdiv_pass_gate
  import cdiv_pkg::*;
(
  input  logic              clk_in,
  input  logic              rst,
  input  logic [CODE_W-1:0] act_code,
  input  logic              div_q,
  output logic              clk_out
);
  logic pass_en;

  // The enable changes on the falling edge only, so the gate cannot chop a high phase.
  always_ff @(negedge clk_in) begin
    pass_en <= !rst && is_pass(act_code);
  end

  assign clk_out = div_q | (clk_in & pass_en);

  // R3
  pass_excl_chk: assert property (@(posedge clk_in) disable iff (rst)
    pass_en |-> !div_q);
endmodule

// File: rtl/core_clk_div.sv
module core_clk_div
  import cdiv_pkg::*;
(
  input  logic              clk_in,
  input  logic              rst,
  input  logic [CODE_W-1:0] div_code,
  output logic              clk_out,
  output logic              clk_en
);
  logic [CODE_W-1:0] act_code;
  logic              div_q;
  logic              load_pt;

  assign clk_en = (div_code != CODE_OFF);

  cdiv_code_reg i_code (
    .clk_in   (clk_in),
    .rst      (rst),
    .load_pt  (load_pt),
    .new_code (div_code),
    .act_code (act_code)
  );

  cdiv_counter i_cnt (
    .clk_in   (clk_in),
    .rst      (rst),
    .act_code (act_code),
    .new_code (div_code),
    .div_q    (div_q),
    .load_pt  (load_pt)
  );

  cdiv_pass_gate i_gate (
    .clk_in   (clk_in),
    .rst      (rst),
    .act_code (act_code),
    .div_q    (div_q),
    .clk_out  (clk_out)
  );

  // R7
  code_hold_chk: assert property (@(posedge clk_in) disable iff (rst)
    (is_div(act_code) && div_q) |=> $stable(act_code));

  // R6
  reset_low_chk: assert property (@(posedge clk_in)
    rst |=> !div_q);
endmodule

// File: tb/test_core_clk_div.sv
`timescale 1ns/1ps
module test_core_clk_div;
  logic       clk_in = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] div_code = 4'd0;
  logic       clk_out;
  logic       clk_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic s = 1'b0;
  logic s_prev = 1'b0;

  core_clk_div i_core_clk_div (
    .clk_in   (clk_in),
    .rst      (rst),
    .div_code (div_code),
    .clk_out  (clk_out),
    .clk_en   (clk_en)
  );

  always #2 clk_in = ~clk_in;

  // {code, expected half-period; 0 means held low}
  localparam logic [9:0] VEC [10] = '{
    {4'd6, 6'd1}, {4'd1, 6'd32}, {4'd4, 6'd4}, {4'd0, 6'd0}, {4'd3, 6'd8},
    {4'd8, 6'd0}, {4'd5, 6'd2}, {4'd15, 6'd0}, {4'd2, 6'd16}, {4'd6, 6'd1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic smp();
    @(negedge clk_in);
    #1;
    s_prev = s;
    s = clk_out;
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) smp();
  endtask

  task automatic sync_rise(output bit ok);
    ok = 0;
    for (int k = 0; k < 300; k++) begin
      smp();
      if (!s_prev && s) begin ok = 1; break; end
    end
  endtask

  task automatic finish_run(input int start, output int len);
    logic lvl;
    len = start;
    lvl = s;
    for (int k = 0; k < 200; k++) begin
      smp();
      if (s == lvl) len++;
      else break;
    end
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      smp();
      if (s) highs++;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int highs, r0, r1, r2, r3, lows;
    bit ok;
    logic [3:0] c;
    int h;

    // R6: reset state, code 0
    settle(5);
    check(clk_out == 1'b0, "R6 out low in reset", clk_out, 0);
    check(clk_en == 1'b0, "R5 enable low for code 0", clk_en, 0);
    rst = 1'b0;
    count_high(40, highs);
    check(highs == 0, "R6 off after reset", highs, 0);

    for (int i = 0; i < 10; i++) begin
      c = VEC[i][9:6];
      h = int'(VEC[i][5:0]);
      div_code = c;
      #0.5;
      check(clk_en == (c != 4'd0), $sformatf("R5 enable code %0d", c), clk_en, c != 4'd0);
      settle(150);
      if (h == 0) begin
        count_high(80, highs);
        check(highs == 0, $sformatf("%s low code %0d", c[3] ? "R4" : "R1", c), highs, 0);
      end else begin
        sync_rise(ok);
        check(ok, $sformatf("R2 rise code %0d", c), ok, 1);
        finish_run(1, r0);
        finish_run(1, r1);
        check(r0 == h, $sformatf("R2 high len code %0d", c), r0, h);
        check(r1 == h, $sformatf("R2 low len code %0d", c), r1, h);
      end
    end

    // R7: slow to fast, changed three samples into a high phase
    div_code = 4'd3;
    settle(150);
    sync_rise(ok);
    smp(); smp();
    div_code = 4'd5;
    finish_run(3, r0); finish_run(1, r1); finish_run(1, r2); finish_run(1, r3);
    check(r0 == 8, "R7 slow->fast run0", r0, 8);
    check(r1 == 8, "R7 slow->fast run1", r1, 8);
    check(r2 == 2, "R7 slow->fast run2", r2, 2);
    check(r3 == 2, "R7 slow->fast run3", r3, 2);

    // R7: fast to slow
    settle(20);
    sync_rise(ok);
    div_code = 4'd3;
    finish_run(1, r0); finish_run(1, r1); finish_run(1, r2); finish_run(1, r3);
    check(r0 == 2, "R7 fast->slow run0", r0, 2);
    check(r1 == 2, "R7 fast->slow run1", r1, 2);
    check(r2 == 8, "R7 fast->slow run2", r2, 8);
    check(r3 == 8, "R7 fast->slow run3", r3, 8);

    // R8: start from off, leading low phase is a full H
    div_code = 4'd0;
    settle(60);
    div_code = 4'd4;
    lows = 0;
    for (int k = 0; k < 100; k++) begin
      smp();
      if (s) break;
      lows++;
    end
    check(lows == 4, "R8 leading low length", lows, 4);
    finish_run(1, r0);
    check(r0 == 4, "R8 first high length", r0, 4);

    // R3: pass-through
    div_code = 4'd7;
    settle(100);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_in); #1;
      check(clk_out == 1'b1, "R3 high with source", clk_out, 1);
      @(negedge clk_in); #1;
      check(clk_out == 1'b0, "R3 low with source", clk_out, 0);
    end

    // R6: reset while running divide-by-2
    div_code = 4'd6;
    settle(20);
    rst = 1'b1;
    settle(2);
    count_high(10, highs);
    check(highs == 0, "R6 low during reset", highs, 0);
    div_code = 4'd0;
    rst = 1'b0;
    count_high(40, highs);
    check(highs == 0, "R6 off after mid-run reset", highs, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule